// File: doc/BRIEF.md
# Spread-Spectrum Switching Clock Generator

This block paces a switching power controller from one fixed system clock. At the start of every switching period it emits a start strobe one system clock wide. It also drives a maximum-on-time window that limits how long the power switch may conduct inside that period. The period is not constant. It follows a slow triangular sweep between a shortest and a longest length, so that switching energy spreads over a band instead of collecting in one spectral line. The default settings give a centre frequency of 130 kHz, a band of about 127.5 to 132.5 kHz (5 kHz peak to peak) and a sweep rate of about 1 kHz.

Internally the period is held as a fixed-point number. Once per switching period it moves by a constant step, and it reverses direction at each band edge. The whole part of that number is the period length in system clocks, and it is also driven out so it can be observed. A new length is taken only when a period ends, so a period is never cut short by the sweep. The enable input starts the pulse train and stops it.

Top module: `jitter_osc`

## Requirements
- R1: While reset is high, and in the cycle after it, `pulse_o` and `dmax_o` are low and `period_o` equals P_AVG = floor(CLK_HZ / F_AVG_HZ). Reset places the sweep at P_AVG (fixed-point value P_AVG·2^FRAC) with the direction set to increasing.
- R2: While enabled, `pulse_o` is high for exactly one system clock at the start of each period. Consecutive rising edges of `pulse_o` are exactly P system clocks apart, where P is the length of the period that begins at the first of the two edges.
- R3: `period_o` changes only in a cycle where `pulse_o` is high. It then holds the length in system clocks of the period that has just started.
- R4: `dmax_o` is high for the first floor(P·DUTY_PCT/100) system clocks of each period, starting in the `pulse_o` cycle, and low for the rest of the period.
- R5: Every period length P stays within P_MIN = floor(CLK_HZ/(F_AVG_HZ+F_DEV_HZ)) and P_MAX = floor(CLK_HZ/(F_AVG_HZ−F_DEV_HZ)). Over a full sweep, both P_MIN and P_MAX occur.
- R6: The sweep works as follows. At the end of each complete period the fixed-point value moves by STEP = floor((P_MAX−P_MIN)·2^FRAC / floor(F_AVG_HZ/(2·F_MOD_HZ))) in the current direction. If the result would reach or pass a band edge, the value is clamped to that edge (P_MAX·2^FRAC or P_MIN·2^FRAC) and the direction reverses. P is the fixed-point value shifted right by FRAC.
- R7: The fixed-point period value changes only at the end of a complete period, never in the middle of one.
- R8: When `en` is low at a clock edge, `pulse_o` and `dmax_o` are low after that edge, the period count restarts and the sweep is frozen. If a period is cut off this way, it is not counted as complete. When `en` is seen high at an edge, `pulse_o` rises after that edge, and the period that starts has the length of the period that was cut off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the switching clock when high |
| pulse_o | output | 1 | One-clock strobe at the start of each period |
| dmax_o | output | 1 | Maximum on-time window |
| period_o | output | PW | Length of the current period in system clocks |

## Verification
All outputs are registered, so `pulse_o`, `dmax_o` and `period_o` follow the edge at which the internal count reaches the matching value. A change on `en` shows on the outputs after the next rising edge. The bench drives inputs and samples outputs on falling edges. It measures each period as the number of falling edges between two strobes, checks `period_o` in the strobe cycle, and counts the window's high cycles over the same span. An arithmetic model of the fixed-point sweep advances only when a full period has been seen, so a period cut off by `en` repeats its expected length when the clock restarts.

// File: rtl/jitter_osc_pkg.sv
package jitter_osc_pkg;

  // length of the maximum on-time window for a period of p clocks
  function automatic int win_len(input int p, input int pct);
    return (p * pct) / 100;
  endfunction

  // fixed-point sweep increment, never zero
  function automatic int sweep_step(input int pmin, input int pmax,
                                    input int frac, input int half_n);
    int s;
    s = ((pmax - pmin) << frac) / ((half_n < 1) ? 1 : half_n);
    return (s < 1) ? 1 : s;
  endfunction

endpackage

// File: rtl/jitter_profile.sv
module jitter_profile #(
  parameter int PW    = 5,
  parameter int FRAC  = 8,
  parameter int P_AVG = 20,
  parameter int P_MIN = 18,
  parameter int P_MAX = 22,
  parameter int STEP  = 102
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [PW-1:0] per_o
);
  localparam int FXW = PW + FRAC + 1;
  localparam logic [FXW-1:0] AVG_FX = FXW'(P_AVG) << FRAC;
  localparam logic [FXW-1:0] MIN_FX = FXW'(P_MIN) << FRAC;
  localparam logic [FXW-1:0] MAX_FX = FXW'(P_MAX) << FRAC;
  localparam logic [FXW-1:0] STEP_FX = FXW'(STEP);

  logic [FXW-1:0] per_fx;
  logic           up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_fx <= AVG_FX;
      up_q   <= 1'b1;
    end else if (adv_i) begin
      if (up_q) begin
        if (per_fx + STEP_FX >= MAX_FX) begin
          per_fx <= MAX_FX;
          up_q   <= 1'b0;
        end else begin
          per_fx <= per_fx + STEP_FX;
        end
      end else begin
        if (per_fx <= MIN_FX + STEP_FX) begin
          per_fx <= MIN_FX;
          up_q   <= 1'b1;
        end else begin
          per_fx <= per_fx - STEP_FX;
        end
      end
    end
  end

  assign per_o = PW'(per_fx >> FRAC);

  // R5
  band_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (per_fx >= MIN_FX) && (per_fx <= MAX_FX));

  // R7
  hold_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(per_fx));

endmodule

// File: rtl/jitter_counter.sv
module jitter_counter
  import jitter_osc_pkg::*;
#(
  parameter int PW       = 5,
  parameter int P_AVG    = 20,
  parameter int DUTY_PCT = 67
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] per_i,
  output logic          adv_o,
  output logic          pulse_o,
  output logic          dmax_o,
  output logic [PW-1:0] period_o
);
  logic [PW-1:0] cnt;
  logic          last;
  int            lim;

  always_comb begin
    lim   = win_len(int'(per_i), DUTY_PCT);
    last  = (cnt == per_i - PW'(1));
    adv_o = en && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pulse_o  <= 1'b0;
      dmax_o   <= 1'b0;
      period_o <= PW'(P_AVG);
    end else if (!en) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
      dmax_o  <= 1'b0;
    end else begin
      pulse_o <= (cnt == '0);
      dmax_o  <= (int'(cnt) < lim);
      cnt     <= last ? '0 : cnt + PW'(1);
      if (cnt == '0) period_o <= per_i;
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  // R4
  window_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> dmax_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pulse_o && !dmax_o));

  // R3
  period_update_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |-> $stable(period_o));

endmodule

// File: rtl/jitter_osc.sv
module jitter_osc
  import jitter_osc_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int F_AVG_HZ = 130_000,
  parameter int F_DEV_HZ = 2_500,
  parameter int F_MOD_HZ = 1_000,
  parameter int DUTY_PCT = 67,
  parameter int FRAC     = 8,
  parameter int PW       = $clog2(CLK_HZ / (F_AVG_HZ - F_DEV_HZ) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          pulse_o,
  output logic          dmax_o,
  output logic [PW-1:0] period_o
);
  localparam int P_AVG  = CLK_HZ / F_AVG_HZ;
  localparam int P_MIN  = CLK_HZ / (F_AVG_HZ + F_DEV_HZ);
  localparam int P_MAX  = CLK_HZ / (F_AVG_HZ - F_DEV_HZ);
  localparam int HALF_N = F_AVG_HZ / (2 * F_MOD_HZ);
  localparam int STEP   = sweep_step(P_MIN, P_MAX, FRAC, HALF_N);

  logic [PW-1:0] per;
  logic          adv;

  jitter_profile #(
    .PW(PW), .FRAC(FRAC), .P_AVG(P_AVG),
    .P_MIN(P_MIN), .P_MAX(P_MAX), .STEP(STEP)
  ) u_prof (
    .clk(clk), .rst(rst), .adv_i(adv), .per_o(per)
  );

  jitter_counter #(
    .PW(PW), .P_AVG(P_AVG), .DUTY_PCT(DUTY_PCT)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(en), .per_i(per), .adv_o(adv),
    .pulse_o(pulse_o), .dmax_o(dmax_o), .period_o(period_o)
  );

endmodule

// File: tb/sim_jitter_osc.sv
module sim_jitter_osc;
  localparam int CLK_HZ = 100_000;
  localparam int F_AVG  = 5_000;
  localparam int F_DEV  = 500;
  localparam int F_MOD  = 250;
  localparam int DUTY   = 67;
  localparam int FRAC   = 8;
  localparam int PW     = $clog2(CLK_HZ / (F_AVG - F_DEV) + 1);
  localparam int P_AVG  = CLK_HZ / F_AVG;
  localparam int P_MIN  = CLK_HZ / (F_AVG + F_DEV);
  localparam int P_MAX  = CLK_HZ / (F_AVG - F_DEV);
  localparam int HALF_N = F_AVG / (2 * F_MOD);
  localparam int STEP   = ((P_MAX - P_MIN) << FRAC) / HALF_N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pulse, dmax;
  logic [PW-1:0] per;

  int errors = 0;
  int checks = 0;
  int fx;
  bit up;
  bit saw_min, saw_max;

  always #5 clk = ~clk;

  jitter_osc #(
    .CLK_HZ(CLK_HZ), .F_AVG_HZ(F_AVG), .F_DEV_HZ(F_DEV),
    .F_MOD_HZ(F_MOD), .DUTY_PCT(DUTY), .FRAC(FRAC)
  ) u0 (
    .clk(clk), .rst(rst), .en(en),
    .pulse_o(pulse), .dmax_o(dmax), .period_o(per)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance the arithmetic sweep model by one complete period (R6)
  task automatic model_step();
    if (up) begin
      if (fx + STEP >= (P_MAX << FRAC)) begin fx = P_MAX << FRAC; up = 0; end
      else fx = fx + STEP;
    end else begin
      if (fx <= (P_MIN << FRAC) + STEP) begin fx = P_MIN << FRAC; up = 1; end
      else fx = fx - STEP;
    end
  endtask

  // entered at a negedge on which pulse is high; leaves at the next pulse
  task automatic run_periods(input int n);
    for (int k = 0; k < n; k++) begin
      int p, len, hi;
      p = fx >> FRAC;
      check("R3 period_o at strobe", int'(per), p);
      check("R5 inside band", int'(p >= P_MIN && p <= P_MAX), 1);
      if (p == P_MIN) saw_min = 1;
      if (p == P_MAX) saw_max = 1;
      len = 0; hi = 0;
      do begin
        if (dmax) hi++;
        len++;
        @(negedge clk);
      end while (!pulse && len < 200);
      check("R2 strobe spacing", len, p);
      check("R4 window length", hi, (p * DUTY) / 100);
      model_step();
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fx = P_AVG << FRAC; up = 1; saw_min = 0; saw_max = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pulse in reset", int'(pulse), 0);
    check("R1 window in reset", int'(dmax), 0);
    check("R1 period in reset", int'(per), P_AVG);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pulse after reset", int'(pulse), 0);
    check("R1 period after reset", int'(per), P_AVG);

    // R2: first strobe one edge after enable
    en = 1'b1;
    @(negedge clk);
    check("R2 first strobe", int'(pulse), 1);
    // R6: first value of an upward sweep
    check("R6 starts at centre", int'(per), P_AVG);
    run_periods(25);

    // R8: stop right at a strobe, cutting that period off
    en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R8 quiet pulse", int'(pulse), 0);
      check("R8 quiet window", int'(dmax), 0);
    end
    en = 1'b1;
    @(negedge clk);
    check("R8 restart strobe", int'(pulse), 1);
    // R7: cut-off period repeats its length, sweep frozen while idle
    check("R7 sweep frozen", int'(per), fx >> FRAC);
    run_periods(30);

    // R5: both band edges reached over the sweep
    check("R5 reached P_MIN", int'(saw_min), 1);
    check("R5 reached P_MAX", int'(saw_max), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule